// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Sample Formatter

This block turns a one-bit oversampled stream from a sigma-delta modulator into 16-bit two's complement sample words. Each accepted input bit counts as +1 or −1. The bits feed a cascade of three running sums that advance at the bit rate. At every R-th accepted bit, three first-difference stages that run at the reduced rate thin the result out. R is 32 or 256. The filter has the response ((1 − z^−R)/(1 − z^−1))^3, which places nulls at every multiple of the output rate.

A formatter cuts the filter result down to a 15-bit sample. It then packs the sample into a 16-bit word in one of two layouts. In the plain data layout the sample sits in the upper fifteen bits above a zero pad bit. In the tagged layout the sample sits in the lower fifteen bits below a flag bit, which reads 0 for data. The ratio and the layout are latched once after reset, so a single decimation period never mixes two settings.

Top module: `sdm_sinc3_decimator`

## Requirements
- R1: A bit is accepted only on a clock where `in_ce` is 1, once the configuration has been latched. An accepted 1 counts as +1 and an accepted 0 counts as −1. Bits presented while `in_ce` is 0 have no effect on any later output word.
- R2: `out_valid` pulses high for exactly one clock per group of R accepted bits, with R = 32 when the latched `ratio_sel` is 0 and R = 256 when it is 1. No other pulse occurs, and two pulses are at least 32 clocks apart.
- R3: Each sum register adds the previous stage's old register value on each accepted bit. The first stage adds the ±1 input. At each R-th accepted bit, the third sum (including that bit) passes through three difference stages. Each difference stage subtracts its own stored input from the previous decimation tick, and all stored values start at zero after reset.
- R4: The 15-bit sample is the filter result shifted right arithmetically by 3·log2(R) − 14: 1 bit at R = 32, which drops an always-zero bit, and 10 bits at R = 256.
- R5: A shifted result of +16384 or more saturates the sample to 0x3FFF. In the data layout the word is then 0x7FFF, which is the only word in that layout with bit 0 set. A constant stream of ones gives this result once the filter has settled.
- R6: Data layout (latched `mode_sel` = 0): word = {sample[14:0], 0}.
- R7: Tagged layout (latched `mode_sel` = 1): word = {0, sample[14:0]}. Bit 15 is the data flag and is always 0.
- R8: A settled constant stream of zeros gives the negative full-scale sample −16384. This is word 0x8000 in the data layout and 0x4000 in the tagged layout. An alternating 1/0 stream gives word 0x0000.
- R9: `ratio_sel` and `mode_sel` are latched on the first clock after the internal reset releases. Later changes have no effect until the next reset.
- R10: While reset is active, `out_valid` is 0 and `out_word` is 0x0000. Reset clears every sum, difference and counter register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_ce | input | 1 | Accept the bit on `in_bit` in this clock |
| in_bit | input | 1 | Modulator output bit |
| ratio_sel | input | 1 | 0: R = 32, 1: R = 256 (latched after reset) |
| mode_sel | input | 1 | 0: data layout, 1: tagged layout (latched after reset) |
| out_word | output | 16 | Formatted sample word, held between strobes |
| out_valid | output | 1 | One-clock strobe for a new `out_word` |

## Verification
The decimation tick can land on the same clock as the acceptance of the first bit of the next period. On that clock the difference stages sample the third sum while the sums advance again. The bench provokes this with long runs where `in_ce` stays high every clock, and with random gaps in `in_ce` around the boundary. It judges each word against a bench model that applies every accepted bit in order and closes a period exactly at the R-th bit. A word that lost or borrowed a bit across the boundary therefore shows up as a mismatch.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  typedef enum logic {
    FMT_DATA16 = 1'b0,
    FMT_MIXED  = 1'b1
  } fmt_mode_e;

  // Right shift that maps the full-gain filter result onto the sample width.
  function automatic int trunc_shift(input int order, input int log2r, input int sample_w);
    return order * log2r - (sample_w - 1);
  endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             en,
  input  logic             bit_in,
  output logic [ACC_W-1:0] sum_out
);

  logic [ORDER:0][ACC_W-1:0] chain;

  // +1 for a one, -1 (all ones) for a zero
  assign chain[0] = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
      acc_d = acc_q;
      if (en) begin
        acc_d = acc_q + chain[g];
      end
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        acc_q <= '0;
      end else begin
        acc_q <= acc_d;
      end
    end

    assign chain[g+1] = acc_q;
  end

  assign sum_out = chain[ORDER];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             tick,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] res_q,
  output logic             res_vld_q
);

  logic [ORDER:0][ACC_W-1:0] chain;
  logic [ACC_W-1:0]          res_d;

  assign chain[0] = din;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [ACC_W-1:0] dly_q;
    logic [ACC_W-1:0] dly_d;

    always_comb begin
      dly_d = dly_q;
      if (tick) begin
        dly_d = chain[g];
      end
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        dly_q <= '0;
      end else begin
        dly_q <= dly_d;
      end
    end

    assign chain[g+1] = chain[g] - dly_q;
  end

  always_comb begin
    res_d = res_q;
    if (tick) begin
      res_d = chain[ORDER];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_q     <= '0;
      res_vld_q <= 1'b0;
    end else begin
      res_q     <= res_d;
      res_vld_q <= tick;
    end
  end

endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt
  import sinc3_pkg::*;
#(
  parameter int ORDER     = 3,
  parameter int ACC_W     = 26,
  parameter int LOG2_R_LO = 5,
  parameter int LOG2_R_HI = 8,
  parameter int SAMPLE_W  = 15,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ACC_W-1:0]  res,
  input  logic              res_vld,
  input  logic              ratio_hi,
  input  fmt_mode_e         mode,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q
);

  localparam int SH_LO = trunc_shift(ORDER, LOG2_R_LO, SAMPLE_W);
  localparam int SH_HI = trunc_shift(ORDER, LOG2_R_HI, SAMPLE_W);
  localparam int PAD_W = WORD_W - SAMPLE_W;
  localparam logic signed [ACC_W-1:0] S_MAX = ACC_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] S_MIN = ~S_MAX;

  logic signed [ACC_W-1:0]  res_s;
  logic signed [ACC_W-1:0]  scaled;
  logic                     pos_sat;
  logic                     neg_sat;
  logic [SAMPLE_W-1:0]      sample;
  logic [WORD_W-1:0]        word_d;

  assign res_s = $signed(res);

  always_comb begin
    if (ratio_hi) begin
      scaled = res_s >>> SH_HI;
    end else begin
      scaled = res_s >>> SH_LO;
    end
    pos_sat = (scaled > S_MAX);
    neg_sat = (scaled < S_MIN);
    if (pos_sat) begin
      sample = S_MAX[SAMPLE_W-1:0];
    end else if (neg_sat) begin
      sample = S_MIN[SAMPLE_W-1:0];
    end else begin
      sample = scaled[SAMPLE_W-1:0];
    end
  end

  always_comb begin
    if (mode == FMT_MIXED) begin
      word_d = {{PAD_W{1'b0}}, sample};
    end else if (pos_sat) begin
      word_d = {sample, {PAD_W{1'b1}}};
    end else begin
      word_d = {sample, {PAD_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (res_vld) begin
        word_q <= word_d;
      end
      valid_q <= res_vld;
    end
  end

endmodule

// File: rtl/sdm_sinc3_decimator.sv
module sdm_sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int ORDER     = 3,
  parameter int LOG2_R_LO = 5,
  parameter int LOG2_R_HI = 8,
  parameter int SAMPLE_W  = 15,
  parameter int WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_ce,
  input  logic              in_bit,
  input  logic              ratio_sel,
  input  logic              mode_sel,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid
);

  localparam int ACC_W = ORDER * LOG2_R_HI + 2;
  localparam int CNT_W = LOG2_R_HI;
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'((1 << LOG2_R_LO) - 1);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'((1 << LOG2_R_HI) - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign srst_n = rst_pipe_q[1];

  // configuration latch
  logic      cfg_loaded_q, cfg_loaded_d;
  logic      cfg_ratio_q,  cfg_ratio_d;
  fmt_mode_e cfg_mode_q,   cfg_mode_d;

  always_comb begin
    cfg_loaded_d = 1'b1;
    cfg_ratio_d  = cfg_ratio_q;
    cfg_mode_d   = cfg_mode_q;
    if (!cfg_loaded_q) begin
      cfg_ratio_d = ratio_sel;
      cfg_mode_d  = fmt_mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_loaded_q <= 1'b0;
      cfg_ratio_q  <= 1'b0;
      cfg_mode_q   <= FMT_DATA16;
    end else begin
      cfg_loaded_q <= cfg_loaded_d;
      cfg_ratio_q  <= cfg_ratio_d;
      cfg_mode_q   <= cfg_mode_d;
    end
  end

  // decimation counter
  logic             acc_en;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_lim;
  logic             tick_q, tick_d;

  assign acc_en  = in_ce & cfg_loaded_q;
  assign cnt_lim = cfg_ratio_q ? LIM_HI : LIM_LO;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (acc_en) begin
      if (cnt_q == cnt_lim) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  // datapath
  logic [ACC_W-1:0] integ_sum;
  logic [ACC_W-1:0] comb_res;
  logic             comb_vld;

  sinc3_integ #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_integ (
    .clk     (clk),
    .srst_n  (srst_n),
    .en      (acc_en),
    .bit_in  (in_bit),
    .sum_out (integ_sum)
  );

  sinc3_comb #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_comb (
    .clk       (clk),
    .srst_n    (srst_n),
    .tick      (tick_q),
    .din       (integ_sum),
    .res_q     (comb_res),
    .res_vld_q (comb_vld)
  );

  sinc3_fmt #(
    .ORDER     (ORDER),
    .ACC_W     (ACC_W),
    .LOG2_R_LO (LOG2_R_LO),
    .LOG2_R_HI (LOG2_R_HI),
    .SAMPLE_W  (SAMPLE_W),
    .WORD_W    (WORD_W)
  ) u_fmt (
    .clk      (clk),
    .srst_n   (srst_n),
    .res      (comb_res),
    .res_vld  (comb_vld),
    .ratio_hi (cfg_ratio_q),
    .mode     (cfg_mode_q),
    .word_q   (out_word),
    .valid_q  (out_valid)
  );

endmodule

// File: rtl/sinc3_checker.sv
module sinc3_checker #(
  parameter int LOG2_R_LO = 5,
  parameter int WORD_W    = 16
) (
  input logic              clk,
  input logic              srst_n,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic              cfg_loaded,
  input logic              cfg_ratio,
  input logic              cfg_mode
);

  localparam int GAP_W = LOG2_R_LO + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'((1 << LOG2_R_LO) - 1);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (out_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  // R2: strobe lasts one clock
  p_pulse_r2: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |=> !out_valid);

  // R2: strobes at least one short period apart
  p_spacing_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && seen_q) |-> (gap_q >= GAP_MIN));

  // R5: in the data layout bit 0 is set only for the saturated word
  p_lsb_sat_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !cfg_mode && out_word[0]) |-> (out_word == 16'h7FFF));

  // R7: flag bit is 0 for data in the tagged layout
  p_flag_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && cfg_mode) |-> !out_word[WORD_W-1]);

  // R9: latched configuration holds until reset
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    cfg_loaded |=> (cfg_loaded && $stable(cfg_ratio) && $stable(cfg_mode)));

  // R10: no strobe while the internal reset is active
  always_ff @(posedge clk) begin
    if (!srst_n) begin
      p_quiet_r10: assert (!out_valid);
    end
  end

endmodule

bind sdm_sinc3_decimator sinc3_checker #(
  .LOG2_R_LO (LOG2_R_LO),
  .WORD_W    (WORD_W)
) u_sinc3_checker (
  .clk        (clk),
  .srst_n     (srst_n),
  .out_valid  (out_valid),
  .out_word   (out_word),
  .cfg_loaded (cfg_loaded_q),
  .cfg_ratio  (cfg_ratio_q),
  .cfg_mode   (cfg_mode_q)
);

// File: tb/sdm_sinc3_decimator_bench.sv
module sdm_sinc3_decimator_bench;

  logic        clk;
  logic        rst_n;
  logic        in_ce;
  logic        in_bit;
  logic        ratio_sel;
  logic        mode_sel;
  logic [15:0] out_word;
  logic        out_valid;

  sdm_sinc3_decimator u_sdm_sinc3_decimator (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ce     (in_ce),
    .in_bit    (in_bit),
    .ratio_sel (ratio_sel),
    .mode_sel  (mode_sel),
    .out_word  (out_word),
    .out_valid (out_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 0;

  // bench model state
  longint m_i1, m_i2, m_i3, m_d1, m_d2, m_d3;
  int     m_cnt;
  int     m_log2;
  bit     m_mixed;
  string  cur_tag;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          prev_valid = 0;

  function automatic logic [15:0] fmt_word(longint r, int l, bit mixed);
    longint s;
    bit     sat;
    s   = r >>> (3 * l - 14);
    sat = (s > 16383);
    if (sat) s = 16383;
    if (s < -16384) s = -16384;
    if (mixed) return {1'b0, s[14:0]};
    if (sat) return 16'h7FFF;
    return {s[14:0], 1'b0};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_accept(bit b);
    longint x, n1, n2, n3, c1, c2, c3;
    logic [15:0] w;
    string t;
    x  = b ? 64'sd1 : -64'sd1;
    n1 = m_i1 + x;
    n2 = m_i2 + m_i1;
    n3 = m_i3 + m_i2;
    m_i1 = n1; m_i2 = n2; m_i3 = n3;
    m_cnt++;
    if (m_cnt == (1 << m_log2)) begin
      m_cnt = 0;
      c1 = m_i3 - m_d1; m_d1 = m_i3;
      c2 = c1 - m_d2;   m_d2 = c1;
      c3 = c2 - m_d3;   m_d3 = c2;
      w  = fmt_word(c3, m_log2, m_mixed);
      t  = cur_tag;
      if (w == 16'h7FFF || (m_mixed && w == 16'h3FFF)) t = "R5";
      if (w == 16'h8000 || (m_mixed && w == 16'h4000)) t = "R8";
      exp_q.push_back(w);
      tag_q.push_back(t);
    end
  endtask

  // kind: 0 random with pct_one ones, 1 all ones, 2 all zeros, 3 alternate
  task automatic run_bits(int n_acc, int kind, int pct_one, int pct_ce);
    int k = 0;
    bit b;
    while (k < n_acc) begin
      @(negedge clk);
      case (kind)
        1:       b = 1'b1;
        2:       b = 1'b0;
        3:       b = k[0];
        default: b = ($urandom_range(99) < pct_one);
      endcase
      if ($urandom_range(99) < pct_ce) begin
        in_ce  = 1'b1;
        in_bit = b;
        model_accept(b);
        k++;
      end else begin
        in_ce  = 1'b0;
        in_bit = $urandom_range(1);
      end
    end
    @(negedge clk);
    in_ce = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R2", "words missing after drain", exp_q.size(), 0);
  endtask

  task automatic do_reset(bit ratio, bit mode);
    @(negedge clk);
    rst_n     = 1'b0;
    in_ce     = 1'b0;
    ratio_sel = ratio;
    mode_sel  = mode;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(out_word == 16'h0000, "R10", "out_word in reset", out_word, 0);
    m_i1 = 0; m_i2 = 0; m_i3 = 0; m_d1 = 0; m_d2 = 0; m_d3 = 0;
    m_cnt   = 0;
    m_log2  = ratio ? 8 : 5;
    m_mixed = mode;
    rst_n   = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin
    logic [15:0] e;
    string t;
    if (rst_n && !done) begin
      if (out_valid && prev_valid) begin
        check(1'b0, "R2", "strobe longer than one clock", 1, 0);
      end
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected word", out_word, 16'hxxxx);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_word === e, t, "output word", out_word, e);
        end
      end
    end
    prev_valid = out_valid;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL R2 watchdog expired: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    rst_n = 1'b0; in_ce = 1'b0; in_bit = 1'b0; ratio_sel = 1'b0; mode_sel = 1'b0;
    repeat (2) @(negedge clk);

    // ratio 32, data layout
    do_reset(1'b0, 1'b0);
    cur_tag = "R1"; run_bits(32 * 30, 0, 50, 70);
    cur_tag = "R6"; run_bits(32 * 12, 0, 20, 100);
    cur_tag = "R6"; run_bits(32 * 12, 0, 85, 100);
    cur_tag = "R5"; run_bits(32 * 6, 1, 0, 100);
    cur_tag = "R8"; run_bits(32 * 6, 2, 0, 90);
    cur_tag = "R8"; run_bits(32 * 6, 3, 0, 100);
    // configuration changes after latch must not matter
    @(negedge clk); ratio_sel = 1'b1; mode_sel = 1'b1;
    cur_tag = "R9"; run_bits(32 * 12, 0, 60, 80);
    cur_tag = "R9"; run_bits(32 * 4, 1, 0, 100);
    drain();

    // ratio 256, tagged layout
    do_reset(1'b1, 1'b1);
    cur_tag = "R7"; run_bits(256 * 10, 0, 50, 85);
    cur_tag = "R5"; run_bits(256 * 5, 1, 0, 100);
    cur_tag = "R8"; run_bits(256 * 5, 2, 0, 100);
    drain();

    // ratio 256, data layout
    do_reset(1'b1, 1'b0);
    cur_tag = "R4"; run_bits(256 * 8, 0, 30, 90);
    cur_tag = "R3"; run_bits(256 * 4, 3, 0, 100);
    cur_tag = "R5"; run_bits(256 * 5, 1, 0, 100);
    drain();

    // ratio 32, tagged layout
    do_reset(1'b0, 1'b1);
    cur_tag = "R7"; run_bits(32 * 20, 0, 50, 75);
    cur_tag = "R5"; run_bits(32 * 6, 1, 0, 100);
    cur_tag = "R8"; run_bits(32 * 6, 2, 0, 100);
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule